// File: doc/BRIEF.md
# I2C Line Input Conditioner

This block sits between the raw SCL and SDA pads of an I2C port and the protocol engine behind it. Each pad signal is brought into the fast clock domain by a two-flop synchronizer. It then passes through its own pulse-rejection filter. The filter discards any excursion that does not last longer than a programmable number of fast-clock ticks. Each tick is 5 ns at the intended 200 MHz clock.

The filtered SDA then gets an extra, programmable internal hold delay measured in a coarser unit of eight ticks (40 ns). An SDA transition that lands close to an SCL falling edge therefore reaches the protocol engine after that edge, so a data change is not read as a start or stop condition. Both outputs leave through a final register.

The filter depth and the hold setting are plain inputs, normally driven from a control register elsewhere. A depth of zero turns filtering off. A hold of zero adds no delay, so SDA stays aligned with SCL.

Top module: `i2c_line_cond`

## Requirements
- R1: While `rst` is high both `scl_clean` and `sda_clean` read 1 whatever the pads do, and they stay 1 after reset until a pad goes low.
- R2: A lasting level change on `scl_pad` appears on `scl_clean` exactly `filt_depth + 4` clock cycles later: two synchronizer stages, `filt_depth + 1` filter cycles and one output register.
- R3: With `filt_depth` = d > 0, a pad pulse lasting d clock cycles or fewer causes no change at all on that line's output.
- R4: A pad pulse lasting d + 1 clock cycles appears on that line's output.
- R5: With `filt_depth` = 0 filtering is off, and a pulse of one clock cycle propagates.
- R6: A lasting level change on `sda_pad` appears on `sda_clean` exactly `filt_depth + 4 + 8 * hold_sel` clock cycles later. One `hold_sel` unit is eight cycles (40 ns at 200 MHz).
- R7: With `hold_sel` = 0, simultaneous level changes on both pads reach both outputs in the same cycle.
- R8: `hold_sel` has no effect on the SCL path latency.
- R9: The two lines are filtered independently: a pulse on one pad never changes the other line's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast filter clock (200 MHz for 5 ns ticks) |
| rst | input | 1 | Synchronous active-high reset |
| scl_pad | input | 1 | Raw asynchronous SCL pad level |
| sda_pad | input | 1 | Raw asynchronous SDA pad level |
| filt_depth | input | 4 | Rejected pulse width in ticks; 0 disables filtering |
| hold_sel | input | 3 | Extra SDA hold in units of eight ticks |
| scl_clean | output | 1 | Synchronized, filtered SCL |
| sda_clean | output | 1 | Synchronized, filtered and hold-delayed SDA |

## Verification
Every combination of filter depth and hold setting is swept with simultaneous lasting edges on both pads. The measured arrival cycle of each output separates the synchronizer and filter latency from the hold delay, and confirms that the hold setting leaves SCL untouched. At every depth, each pad also receives pulses exactly d and d + 1 cycles wide. The first must vanish and the second must pass, which pins the filter threshold to within one tick; the silent opposite line shows that the filters are independent. Depth zero with a single-cycle pulse confirms the bypass.

// File: rtl/i2c_cond_pkg.sv
package i2c_cond_pkg;
  localparam int DEPTH_W   = 4;
  localparam int HOLD_W    = 3;
  localparam int HOLD_UNIT = 8;
  localparam int SYNC_LEN  = 2;
  localparam int LINES     = 2;
  localparam int LINE_SCL  = 0;
  localparam int LINE_SDA  = 1;
endpackage

// File: rtl/i2c_sync_chain.sv
module i2c_sync_chain #(
  parameter int  STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  AST_SYNC_2FF: assert property (@(posedge clk) disable iff (rst)
    (STAGES == 2 && age >= 2'd2) |-> (q_sync == $past(d_async, 2))); // R2
endmodule

// File: rtl/i2c_pulse_filter.sv
module i2c_pulse_filter #(
  parameter int  DEPTH_W = 4,
  parameter logic RST_VAL = 1'b1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic [DEPTH_W-1:0] depth,
  output logic               dout
);
  logic [DEPTH_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      dout    <= RST_VAL;
      run_cnt <= '0;
    end else if (din == dout) begin
      run_cnt <= '0;
    end else if (run_cnt >= depth) begin
      dout    <= din;
      run_cnt <= '0;
    end else begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_FILT_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (seen && !$stable(dout)) |-> (dout == $past(din))); // R4

  AST_FILT_BYPASS: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(depth) == '0) |-> (dout == $past(din))); // R5
endmodule

// File: rtl/i2c_hold_delay.sv
module i2c_hold_delay #(
  parameter int  HOLD_W    = 3,
  parameter int  HOLD_UNIT = 8,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              din,
  input  logic [HOLD_W-1:0] hold,
  output logic              dout
);
  localparam int MAX_LEN = ((1 << HOLD_W) - 1) * HOLD_UNIT;
  localparam int IDX_W   = $clog2(MAX_LEN + 1);

  logic [MAX_LEN-1:0] line;
  logic [IDX_W-1:0]   tap_idx;
  logic               tap;

  always_ff @(posedge clk) begin
    if (rst) line <= {MAX_LEN{RST_VAL}};
    else     line <= {line[MAX_LEN-2:0], din};
  end

  always_comb begin
    tap_idx = IDX_W'(int'(hold) * HOLD_UNIT);
    if (hold == '0) tap = din;
    else            tap = line[tap_idx - 1'b1];
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= RST_VAL;
    else     dout <= tap;
  end

  logic [3:0] age;
  always_ff @(posedge clk) begin
    if (rst)                age <= '0;
    else if (age != 4'd15)  age <= age + 4'd1;
  end

  AST_HOLD_ONE: assert property (@(posedge clk) disable iff (rst)
    (HOLD_UNIT == 8 && age >= 4'd10 && $past(hold) == HOLD_W'(1))
      |-> (dout == $past(din, 9))); // R6
endmodule

// File: rtl/i2c_line_cond.sv
module i2c_line_cond
  import i2c_cond_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_pad,
  input  logic               sda_pad,
  input  logic [DEPTH_W-1:0] filt_depth,
  input  logic [HOLD_W-1:0]  hold_sel,
  output logic               scl_clean,
  output logic               sda_clean
);
  logic [LINES-1:0] pad_vec;
  logic [LINES-1:0] sync_vec;
  logic [LINES-1:0] filt_vec;

  assign pad_vec[LINE_SCL] = scl_pad;
  assign pad_vec[LINE_SDA] = sda_pad;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    i2c_sync_chain #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async (pad_vec[g]),
      .q_sync  (sync_vec[g])
    );
    i2c_pulse_filter #(.DEPTH_W(DEPTH_W), .RST_VAL(1'b1)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .din   (sync_vec[g]),
      .depth (filt_depth),
      .dout  (filt_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) scl_clean <= 1'b1;
    else     scl_clean <= filt_vec[LINE_SCL];
  end

  i2c_hold_delay #(.HOLD_W(HOLD_W), .HOLD_UNIT(HOLD_UNIT), .RST_VAL(1'b1)) u_hold (
    .clk  (clk),
    .rst  (rst),
    .din  (filt_vec[LINE_SDA]),
    .hold (hold_sel),
    .dout (sda_clean)
  );
endmodule

// File: tb/tb_i2c_line_cond.sv
`timescale 1ns/1ps
module tb_i2c_line_cond;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_pad = 1'b0;
  logic       sda_pad = 1'b0;
  logic [3:0] filt_depth = 4'd0;
  logic [2:0] hold_sel = 3'd0;
  logic       scl_clean, sda_clean;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  i2c_line_cond dut (
    .clk(clk), .rst(rst), .scl_pad(scl_pad), .sda_pad(sda_pad),
    .filt_depth(filt_depth), .hold_sel(hold_sel),
    .scl_clean(scl_clean), .sda_clean(sda_clean)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (90) @(negedge clk);
  endtask

  task automatic edge_both(input int d, input int h);
    int cs = -1, cd = -1;
    logic os = scl_clean, od = sda_clean;
    scl_pad = ~scl_pad;
    sda_pad = ~sda_pad;
    for (int i = 1; i <= 120; i++) begin
      @(negedge clk);
      if (cs < 0 && scl_clean != os) cs = i;
      if (cd < 0 && sda_clean != od) cd = i;
    end
    check(cs == d + 4, "R2 scl latency", cs, d + 4);
    check(cd == d + 4 + 8 * h, "R6 sda latency", cd, d + 4 + 8 * h);
    if (h == 0) check(cd == cs, "R7 aligned at hold 0", cd, cs);
    if (h == 7) check(cs == d + 4, "R8 scl ignores hold", cs, d + 4);
  endtask

  task automatic pulse(input int line, input int w, input int win,
                       output bit hit_own, output bit hit_other);
    logic os = scl_clean, od = sda_clean;
    hit_own = 1'b0;
    hit_other = 1'b0;
    if (line == 0) scl_pad = ~scl_pad; else sda_pad = ~sda_pad;
    for (int i = 1; i <= win; i++) begin
      @(negedge clk);
      if (i == w) begin
        if (line == 0) scl_pad = ~scl_pad; else sda_pad = ~sda_pad;
      end
      if (line == 0) begin
        if (scl_clean != os) hit_own = 1'b1;
        if (sda_clean != od) hit_other = 1'b1;
      end else begin
        if (sda_clean != od) hit_own = 1'b1;
        if (scl_clean != os) hit_other = 1'b1;
      end
    end
  endtask

  initial begin
    bit own, oth;
    repeat (4) @(negedge clk);
    check(scl_clean == 1'b1, "R1 scl in reset", int'(scl_clean), 1);
    check(sda_clean == 1'b1, "R1 sda in reset", int'(sda_clean), 1);
    scl_pad = 1'b1;
    sda_pad = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(scl_clean == 1'b1, "R1 scl after reset", int'(scl_clean), 1);
    check(sda_clean == 1'b1, "R1 sda after reset", int'(sda_clean), 1);

    for (int d = 0; d < 16; d++) begin
      for (int h = 0; h < 8; h++) begin
        filt_depth = 4'(d);
        hold_sel = 3'(h);
        settle();
        edge_both(d, h);
      end
    end

    hold_sel = 3'd1;
    for (int d = 0; d < 16; d++) begin
      filt_depth = 4'(d);
      for (int line = 0; line < 2; line++) begin
        settle();
        if (d > 0) begin
          pulse(line, d, d + 40, own, oth);
          check(!own, "R3 pulse of depth rejected", int'(own), 0);
          check(!oth, "R9 other line quiet", int'(oth), 0);
          settle();
        end
        pulse(line, d + 1, d + 40, own, oth);
        if (d == 0) check(own, "R5 one-cycle pulse passes at depth 0", int'(own), 1);
        else        check(own, "R4 pulse of depth+1 passes", int'(own), 1);
        check(!oth, "R9 other line quiet", int'(oth), 0);
      end
    end

    settle();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule